// File: doc/BRIEF.md
# Vectored Interrupt Controller with Master Enable

This block arbitrates the interrupts of a small microcontroller core among three sources: a falling edge on an external pin and the overflow pulses of two timers. A single control register holds a master enable, one enable bit for each source and one latched request flag for each source. When at least one enabled request is pending, the master enable is set and the core's return stack has room, the controller asks the core for a call and supplies the fixed vector of the highest-priority pending source.

When the core accepts the call, the controller clears the flag of the source it served and clears the master enable, so no second interrupt can cut into the handler. Requests that arrive in the meantime are still latched and are served later. The interrupt-return strobe from the core sets the master enable again. A plain return leaves it alone. Software may also write the master enable back to 1 inside a handler to allow nesting. The return stack, the timers and instruction decode are outside this block. It only sees a stack-full level and single-cycle strobes.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the control register reads 0x00 and `irq_req_o` is low.
- R2: A high-to-low transition on `ext_pin_i` sets flag bit 4 of the control register.
  - The flag becomes visible three clock edges after the pin is first sampled low: two synchronizer stages, then the edge detector.
  - A low-to-high transition sets nothing.
- R3: A one-cycle pulse on `tmr_ovf_i[0]` sets flag bit 5 on the next edge, and a pulse on `tmr_ovf_i[1]` sets flag bit 6.
- R4: `irq_req_o` is high exactly when all of the following hold:
  - bit 0 (master enable) is 1;
  - some source has both its flag (bits 4..6) and its enable (bits 1..3, in the order external, timer 0, timer 1) set;
  - `stack_full_i` is low.
- R5: `irq_vec_o` gives the vector of the highest-priority source whose flag and enable are both set, whatever the master enable and stack state:
  - external 0x04, timer 0 0x08, timer 1 0x0C;
  - priority is external, then timer 0, then timer 1;
  - the vector is 0x00 when no such source exists.
- R6: An `irq_ack_i` pulse while `irq_req_o` is high clears the flag of the source being vectored and clears the master enable on the next edge. The other flags and the enables keep their values.
- R7: Requests that arrive while the master enable is 0 are latched in their flags. They raise `irq_req_o` once the master enable is set.
- R8: A `reti_i` strobe sets the master enable on the next edge. A `ret_i` strobe changes nothing.
- R9: While `stack_full_i` is high, `irq_req_o` stays low and an `irq_ack_i` pulse leaves the register unchanged.
- R10: Register writes behave as follows:
  - A write with `cfg_addr_i` equal to 0x0B loads bits 6..0 from `cfg_wdata_i`. Bit 7 always reads 0.
  - Writes to any other address are ignored.
  - A source event in the same cycle as a write sets its flag, overriding the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin, idle high |
| tmr_ovf_i | input | 2 | Timer overflow pulses, bit 0 timer 0, bit 1 timer 1 |
| stack_full_i | input | 1 | Core return stack is full |
| cfg_wr_i | input | 1 | Data-space write strobe |
| cfg_addr_i | input | 8 | Data-space write address |
| cfg_wdata_i | input | 8 | Data-space write data |
| ctrl_rd_o | output | 8 | Current control register value |
| irq_req_o | output | 1 | Call request to the core |
| irq_vec_o | output | 8 | Vector address of the selected source |
| irq_ack_i | input | 1 | Core accepts the call |
| reti_i | input | 1 | Interrupt-return executed |
| ret_i | input | 1 | Plain return executed |

## Verification
The main function is swept over every combination of master enable, the three enables, the three flags and the stack-full level. This separates a gating error on any single term of the request condition from an error in the priority order of the vector. A second sweep acknowledges every non-empty flag pattern with all sources enabled, which shows whether exactly the top-priority flag is cleared and the rest survive. Directed sequences cover the rest:
- the pin's edge latency against its rising edge;
- latching while the master enable is off;
- acknowledge while the stack is full;
- an interrupt return compared with a plain return;
- a write to a wrong address;
- a write that collides with a timer pulse.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Shared layout constants of the interrupt control register.
// Assumes the register packs: master enable, then one enable bit per
// source, then one flag per source, upper bits unused.
package irq_pkg;
    localparam int IRQ_NSRC    = 3;
    localparam int IRQ_REG_W   = 8;
    localparam int IRQ_EMI_BIT = 0;
    localparam int IRQ_EN_LSB  = 1;
    localparam int IRQ_FLG_LSB = IRQ_EN_LSB + IRQ_NSRC;
endpackage

// File: rtl/irq_edge_sync.sv
// Module irq_edge_sync
// Synchronizes an asynchronous, idle-high pin through STAGES flops and
// emits a one-cycle pulse on each high-to-low transition.
// Assumes the pin is high when reset is released.
module irq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    logic [STAGES:0] shift_q;

    // Shift the pin through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '1;
        else        shift_q <= {shift_q[STAGES-1:0], pin_i};
    end

    // Falling edge: old synchronized value high, new one low.
    always_comb fall_o = shift_q[STAGES] & ~shift_q[STAGES-1];

    assert_fall_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/irq_prio_pick.sv
// Module irq_prio_pick
// Fixed-priority selection among pending sources; index 0 wins.
// Produces a one-hot grant and the vector (index+1)*STEP, or 0 if none.
module irq_prio_pick #(
    parameter int N     = 3,
    parameter int VEC_W = 8,
    parameter int STEP  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pend_i,
    output logic [N-1:0]     grant_o,
    output logic [VEC_W-1:0] vec_o
);
    // Walk from highest to lowest priority, granting the first pending one.
    always_comb begin
        logic taken;
        taken   = 1'b0;
        grant_o = '0;
        vec_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (pend_i[i] && !taken) begin
                grant_o[i] = 1'b1;
                vec_o      = VEC_W'((i + 1) * STEP);
                taken      = 1'b1;
            end
        end
    end

    assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    assert_grant_when_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_i) |-> (vec_o != '0));
endmodule

// File: rtl/irq_ctrl_reg.sv
// Module irq_ctrl_reg
// Holds master enable, source enables and request flags.
// The update order within one cycle is fixed:
//   1. a software write loads the register;
//   2. a taken acknowledge clears the granted flag and the master enable;
//   3. source events set their flags;
//   4. an interrupt return sets the master enable.
module irq_ctrl_reg
    import irq_pkg::*;
#(
    parameter int N     = IRQ_NSRC,
    parameter int REG_W = IRQ_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             ack_take_i,
    input  logic [N-1:0]     grant_i,
    input  logic [N-1:0]     evt_i,
    input  logic             reti_i,
    output logic [REG_W-1:0] q_o
);
    localparam int FLG = 1 + N;
    localparam int USED = 1 + 2 * N;
    localparam logic [REG_W-1:0] USED_MASK = REG_W'((1 << USED) - 1);

    logic [REG_W-1:0] nxt;

    // Compose the next register value in the fixed priority order.
    always_comb begin
        nxt = q_o;
        if (wr_hit_i) nxt = wdata_i & USED_MASK;
        if (ack_take_i) begin
            nxt[FLG +: N] = nxt[FLG +: N] & ~grant_i;
            nxt[0]        = 1'b0;
        end
        nxt[FLG +: N] = nxt[FLG +: N] | evt_i;
        if (reti_i) nxt[0] = 1'b1;
    end

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= nxt;
    end

    assert_reti_sets_emi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> q_o[0]);
    assert_ack_clears_emi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take_i && !reti_i) |=> !q_o[0]);
    assert_evt_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((q_o[FLG +: N] & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/irq_vector_ctrl.sv
// Module irq_vector_ctrl
// Three-source vectored interrupt controller with master enable.
// Source 0 is the synchronized falling edge of ext_pin_i; sources 1 and 2
// are timer overflow pulses (one cycle each). Assumes the core raises
// irq_ack_i for one cycle when it takes the call, and reti_i / ret_i for
// one cycle per executed return.
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          VEC_W       = 8,
    parameter int          VEC_STEP    = 4,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  CTRL_ADDR   = 8'h0B
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ext_pin_i,
    input  logic [IRQ_NSRC-2:0]  tmr_ovf_i,
    input  logic                 stack_full_i,
    input  logic                 cfg_wr_i,
    input  logic [ADDR_W-1:0]    cfg_addr_i,
    input  logic [IRQ_REG_W-1:0] cfg_wdata_i,
    output logic [IRQ_REG_W-1:0] ctrl_rd_o,
    output logic                 irq_req_o,
    output logic [VEC_W-1:0]     irq_vec_o,
    input  logic                 irq_ack_i,
    input  logic                 reti_i,
    input  logic                 ret_i
);
    localparam int N = IRQ_NSRC;

    logic          ext_fall;
    logic [N-1:0]  evt;
    logic [N-1:0]  pend;
    logic [N-1:0]  grant;
    logic          wr_hit;
    logic          ack_take;

    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin_i),
        .fall_o (ext_fall)
    );

    // Gather source events: the pin edge first, then the timers.
    always_comb evt = {tmr_ovf_i, ext_fall};

    // A write takes effect only at the register's own address.
    always_comb wr_hit = cfg_wr_i && (cfg_addr_i == ADDR_W'(CTRL_ADDR));

    // Sources that are both flagged and enabled.
    always_comb pend = ctrl_rd_o[IRQ_FLG_LSB +: N] & ctrl_rd_o[IRQ_EN_LSB +: N];

    irq_prio_pick #(.N(N), .VEC_W(VEC_W), .STEP(VEC_STEP)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend),
        .grant_o (grant),
        .vec_o   (irq_vec_o)
    );

    // Request the call only with master enable set and stack room left.
    always_comb irq_req_o = ctrl_rd_o[IRQ_EMI_BIT] & (|pend) & ~stack_full_i;

    // Acknowledge counts only against a live request.
    always_comb ack_take = irq_ack_i & irq_req_o;

    irq_ctrl_reg #(.N(N), .REG_W(IRQ_REG_W)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit_i   (wr_hit),
        .wdata_i    (cfg_wdata_i),
        .ack_take_i (ack_take),
        .grant_i    (grant),
        .evt_i      (evt),
        .reti_i     (reti_i),
        .q_o        (ctrl_rd_o)
    );

    assert_full_holds_emi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_full_i && !wr_hit && !reti_i) |=> $stable(ctrl_rd_o[IRQ_EMI_BIT]));
    assert_ret_keeps_emi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !reti_i && !wr_hit && !(irq_ack_i && irq_req_o))
        |=> $stable(ctrl_rd_o[IRQ_EMI_BIT]));
    assert_ack_drops_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && irq_req_o && !reti_i && !wr_hit) |=> !irq_req_o);
    assert_bit7_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd_o[IRQ_REG_W-1] == 1'b0);
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b1;
    logic [1:0] tmr = 2'b00;
    logic       full = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] ctrl;
    logic       req;
    logic [7:0] vec;
    logic       ack = 1'b0;
    logic       reti = 1'b0;
    logic       ret = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .tmr_ovf_i(tmr),
        .stack_full_i(full), .cfg_wr_i(wr), .cfg_addr_i(addr),
        .cfg_wdata_i(wdata), .ctrl_rd_o(ctrl), .irq_req_o(req),
        .irq_vec_o(vec), .irq_ack_i(ack), .reti_i(reti), .ret_i(ret)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int pend_of(input logic [7:0] c);
        return int'(c[6:4] & c[3:1]);
    endfunction

    function automatic int exp_vec(input logic [7:0] c);
        int p = pend_of(c);
        if (p[0]) return 4;
        if (p[1]) return 8;
        if (p[2]) return 12;
        return 0;
    endfunction

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ctrl", ctrl, 0);
        chk("R1 reset req", req, 0);

        // R4/R5 sweep over all register and stack states.
        for (int e = 0; e < 2; e++)
            for (int en = 0; en < 8; en++)
                for (int fl = 0; fl < 8; fl++)
                    for (int f = 0; f < 2; f++) begin
                        c = {1'b0, 3'(fl), 3'(en), 1'(e)};
                        full = 1'(f);
                        wr_reg(8'h0B, c);
                        chk("R4 req", req,
                            int'(e == 1 && pend_of(c) != 0 && f == 0));
                        chk("R5 vec", vec, exp_vec(c));
                    end
        full = 1'b0;

        // R6 acknowledge each flag pattern with all sources enabled.
        for (int fl = 1; fl < 8; fl++) begin
            c = {1'b0, 3'(fl), 3'b111, 1'b1};
            wr_reg(8'h0B, c);
            pulse_ack();
            chk("R6 ack clear", ctrl,
                int'({1'b0, 3'(fl & (fl - 1)), 3'b111, 1'b0}));
        end

        // R10 bit 7 and wrong-address write.
        wr_reg(8'h0B, 8'hFF);
        chk("R10 bit7 zero", ctrl, 8'h7F);
        wr_reg(8'h0B, 8'h00);
        wr_reg(8'h0C, 8'h7F);
        chk("R10 wrong addr", ctrl, 8'h00);

        // R10 timer event wins against a clearing write.
        @(negedge clk); wr = 1'b1; addr = 8'h0B; wdata = 8'h00; tmr = 2'b01;
        @(negedge clk); wr = 1'b0; tmr = 2'b00;
        chk("R10 event over write", ctrl, 8'h20);

        // R3 timer pulses.
        wr_reg(8'h0B, 8'h00);
        @(negedge clk); tmr = 2'b10;
        @(negedge clk); tmr = 2'b00;
        chk("R3 timer1 flag", ctrl, 8'h40);
        wr_reg(8'h0B, 8'h00);
        @(negedge clk); tmr = 2'b01;
        @(negedge clk); tmr = 2'b00;
        chk("R3 timer0 flag", ctrl, 8'h20);

        // R2 falling-edge latency and R7 latching with master enable off.
        wr_reg(8'h0B, 8'h02);
        @(negedge clk); ext_pin = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R2 not yet", ctrl, 8'h02);
        @(negedge clk);
        chk("R2 ext flag", ctrl, 8'h12);
        chk("R7 held off", req, 0);
        wr_reg(8'h0B, 8'h13);
        chk("R7 served later req", req, 1);
        chk("R7 served later vec", vec, 4);
        wr_reg(8'h0B, 8'h02);
        @(negedge clk); ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 rising ignored", ctrl, 8'h02);

        // R9 acknowledge ignored while stack full.
        wr_reg(8'h0B, 8'h25);
        full = 1'b1;
        pulse_ack();
        chk("R9 full ack ignored", ctrl, 8'h25);
        chk("R9 full no req", req, 0);
        full = 1'b0;
        @(negedge clk);
        chk("R9 freed req", req, 1);
        chk("R9 freed vec", vec, 8);

        // R8 interrupt return versus plain return.
        pulse_ack();
        chk("R6 ack timer0", ctrl, 8'h04);
        @(negedge clk); ret = 1'b1;
        @(negedge clk); ret = 1'b0;
        chk("R8 ret keeps", ctrl, 8'h04);
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
        chk("R8 reti sets", ctrl, 8'h05);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule